// File: doc/BRIEF.md
# Dual-Channel Serial Audio Input Register

This block takes two serial audio streams, left and right, that share one bit clock but each have their own data line and their own latch line. Every rising bit-clock edge pushes one data bit into each channel's shift register. A falling edge on a channel's latch line copies the newest 18 bits of that channel into a parallel holding register, which then feeds the converter that follows. There is no bit counter and no framing. The latch edge alone decides which bits form a word, so a sender may stream words longer than 18 bits and only the tail is kept.

All five serial inputs are asynchronous to the block. They pass through a synchroniser into a system clock that runs at least four times faster than the bit clock, and edges are found from the synchronised samples. Each channel presents its held word in two forms: the received two's complement value, and an offset-binary copy for converters that expect unsigned codes. Each channel also gives a one-cycle pulse whenever its held word is reloaded. The data lines may be tied together, and so may the latch lines; with both pairs tied, the two channels load the same word on the same cycle.

Top module: `dsar_serial_in`

## Requirements
- R1: While reset is asserted and directly after it, both held words are 0 (two's complement midscale), both offset-binary outputs are 0x20000, both strobes are low, and both shift registers are empty (all zero).
- R2: A data bit is taken only on a rising edge of the bit clock. A falling bit-clock edge shifts nothing. Bits arrive most significant first, so the newest bit becomes bit 0 of the word.
- R3: A falling edge on a channel's latch input loads the 18 most recently shifted bits of that channel into its held word. The held word changes on the third system clock edge after the latch input changes, with the default two synchroniser stages.
- R4: When more than 18 bits arrive between latch edges, only the last 18 are kept. When fewer arrive, the remaining upper positions hold the bits that came before them, which are zeros after reset.
- R5: A rising latch edge, and any cycle with no falling latch edge, leaves the held word unchanged.
- R6: The channels are independent: a latch edge on one channel leaves the other channel's held word and strobe unchanged.
- R7: Every capture gives exactly one single-cycle high pulse on that channel's update strobe, in the same cycle in which the new held word first appears.
- R8: The offset-binary output equals the held word with bit 17 inverted, so 0 maps to 0x20000 and 0x2A5A3 maps to 0x0A5A3.
- R9: When a rising bit-clock edge and a falling latch edge are seen in the same system cycle, the bit is shifted in first, and the captured word includes it as bit 0.
- R10: With both data lines tied together and both latch lines tied together, both channels hold the same word and pulse their strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_i | input | 1 | Shared serial bit clock (asynchronous) |
| din_l_i | input | 1 | Left serial data |
| din_r_i | input | 1 | Right serial data |
| lat_l_i | input | 1 | Left latch; a falling edge loads the word |
| lat_r_i | input | 1 | Right latch; a falling edge loads the word |
| word_l_o | output | 18 | Left held word, two's complement |
| word_r_o | output | 18 | Right held word, two's complement |
| obin_l_o | output | 18 | Left held word, offset binary |
| obin_r_o | output | 18 | Right held word, offset binary |
| upd_l_o | output | 1 | Left one-cycle update strobe |
| upd_r_o | output | 1 | Right one-cycle update strobe |

## Verification
A bit-clock rising edge and a latch falling edge can land in the same synchronised cycle. If they do, the shift and the capture happen together, and the captured word must already contain the new bit. The bench provokes this by raising the bit clock for the eighteenth bit and dropping the latch line at the same clock edge. It then expects the word whose least significant bit is that last bit, never the older window shifted by one. A queue-based reference model runs every cycle alongside the design and processes bit-clock rises before latch falls, so any wrong ordering shows up as a word mismatch in the cycle of the strobe.

// File: rtl/dsar_pkg.sv
package dsar_pkg;

  // Per-channel control derived from the synchronised serial inputs.
  typedef struct packed {
    logic shift;    // rising bit-clock edge seen this cycle
    logic bit_v;    // synchronised data value to shift in
    logic capture;  // falling latch edge seen this cycle
  } chan_ctl_t;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/dsar_rst_sync.sv
module dsar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsar_edge_sync.sv
module dsar_edge_sync #(
  parameter int unsigned N      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] stage_q [STAGES];
  logic [N-1:0] stage_d [STAGES];
  logic [N-1:0] last_q;

  always_comb begin
    stage_d[0] = async_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= '0;
      end
      last_q <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= stage_d[i];
      end
      last_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~last_q;
  assign fall_o  = ~stage_q[STAGES-1] & last_q;

endmodule

// File: rtl/dsar_chan.sv
module dsar_chan
  import dsar_pkg::*;
#(
  parameter int unsigned WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_ctl_t         ctl_i,
  output logic [WORD_W-1:0] word_o,
  output logic              strobe_o
);

  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_d;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] hold_d;
  logic              stb_q;
  logic              stb_d;

  // Shift happens before capture: a capture in a shift cycle sees the new bit.
  always_comb begin
    sr_d   = {sr_q[WORD_W-2:0], ctl_i.bit_v};
    hold_d = ctl_i.shift ? sr_d : sr_q;
    stb_d  = ctl_i.capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      hold_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      if (ctl_i.shift) begin
        sr_q <= sr_d;
      end
      if (ctl_i.capture) begin
        hold_q <= hold_d;
      end
      stb_q <= stb_d;
    end
  end

  assign word_o   = hold_q;
  assign strobe_o = stb_q;

endmodule

// File: rtl/dsar_serial_in.sv
module dsar_serial_in
  import dsar_pkg::*;
#(
  parameter int unsigned WORD_W      = 18,
  parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              din_l_i,
  input  logic              din_r_i,
  input  logic              lat_l_i,
  input  logic              lat_r_i,
  output logic [WORD_W-1:0] word_l_o,
  output logic [WORD_W-1:0] word_r_o,
  output logic [WORD_W-1:0] obin_l_o,
  output logic [WORD_W-1:0] obin_r_o,
  output logic              upd_l_o,
  output logic              upd_r_o
);

  localparam int unsigned NCH     = 2;
  localparam int unsigned NSIG    = 1 + 2 * NCH;
  localparam int unsigned IDX_CLK = 0;
  localparam int unsigned IDX_DAT = 1;
  localparam int unsigned IDX_LAT = 1 + NCH;

  logic            rst_n_int;
  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] lvl;
  logic [NSIG-1:0] rise;
  logic [NSIG-1:0] fall;

  logic [WORD_W-1:0] word_arr [NCH];
  logic [WORD_W-1:0] obin_arr [NCH];
  logic [NCH-1:0]    upd_vec;

  dsar_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_int)
  );

  assign raw_in = {lat_r_i, lat_l_i, din_r_i, din_l_i, bclk_i};

  dsar_edge_sync #(
    .N      (NSIG),
    .STAGES (SYNC_STAGES)
  ) u_edge_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i (raw_in),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  // Edges that no channel consumes.
  logic unused_edges;
  assign unused_edges = ^{rise[NSIG-1:1], fall[IDX_LAT-1:0], lvl[IDX_CLK], lvl[NSIG-1:IDX_LAT]};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_ctl_t ctl;

    assign ctl.shift   = rise[IDX_CLK];
    assign ctl.bit_v   = lvl[IDX_DAT + c];
    assign ctl.capture = fall[IDX_LAT + c];

    dsar_chan #(
      .WORD_W (WORD_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .ctl_i    (ctl),
      .word_o   (word_arr[c]),
      .strobe_o (upd_vec[c])
    );

    assign obin_arr[c] = {~word_arr[c][WORD_W-1], word_arr[c][WORD_W-2:0]};
  end

  assign word_l_o = word_arr[0];
  assign word_r_o = word_arr[1];
  assign obin_l_o = obin_arr[0];
  assign obin_r_o = obin_arr[1];
  assign upd_l_o  = upd_vec[0];
  assign upd_r_o  = upd_vec[1];

endmodule

// File: rtl/dsar_serial_in_chk.sv
module dsar_serial_in_chk #(
  parameter int unsigned WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_l_o,
  input logic [WORD_W-1:0] word_r_o,
  input logic [WORD_W-1:0] obin_l_o,
  input logic [WORD_W-1:0] obin_r_o,
  input logic              upd_l_o,
  input logic              upd_r_o
);

  // R1
  rst_mid_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word_l_o == '0 && !upd_l_o));

  // R1
  rst_mid_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word_r_o == '0 && !upd_r_o));

  // R5
  hold_l_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_l_o |-> $stable(word_l_o));

  // R5
  hold_r_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_r_o |-> $stable(word_r_o));

  // R7
  strobe_l_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_l_o |=> !upd_l_o);

  // R7
  strobe_r_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_r_o |=> !upd_r_o);

  // R8
  obin_l_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obin_l_o ^ word_l_o) == (WORD_W'(1) << (WORD_W - 1)));

  // R8
  obin_r_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obin_r_o ^ word_r_o) == (WORD_W'(1) << (WORD_W - 1)));

endmodule

bind dsar_serial_in dsar_serial_in_chk #(
  .WORD_W (WORD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .word_l_o (word_l_o),
  .word_r_o (word_r_o),
  .obin_l_o (obin_l_o),
  .obin_r_o (obin_r_o),
  .upd_l_o  (upd_l_o),
  .upd_r_o  (upd_r_o)
);

// File: tb/tb_dsar_serial_in.sv
module tb_dsar_serial_in;

  localparam int W = 18;
  localparam logic [W-1:0] SIGN = 18'h20000;
  localparam logic [W-1:0] MASK = 18'h3FFFF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n  = 1'b0;
  logic bclk   = 1'b0;
  logic din_l  = 1'b0;
  logic din_r  = 1'b0;
  logic lat_l  = 1'b0;
  logic lat_r  = 1'b0;
  logic [W-1:0] word_l_o, word_r_o, obin_l_o, obin_r_o;
  logic upd_l_o, upd_r_o;

  int n_chk = 0;
  int n_fail = 0;
  int upd_l_seen = 0;
  int upd_r_seen = 0;
  int tie_mism = 0;
  bit in_tie = 1'b0;
  bit done = 1'b0;

  dsar_serial_in dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_i   (bclk),
    .din_l_i  (din_l),
    .din_r_i  (din_r),
    .lat_l_i  (lat_l),
    .lat_r_i  (lat_r),
    .word_l_o (word_l_o),
    .word_r_o (word_r_o),
    .obin_l_o (obin_l_o),
    .obin_r_o (obin_r_o),
    .upd_l_o  (upd_l_o),
    .upd_r_o  (upd_r_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: history of samples, queue of received bits.
  bit mq_l[$];
  bit mq_r[$];
  logic [4:0] p1, p2, p3;
  logic [W-1:0] ew_l, ew_r;
  logic eu_l, eu_r;

  function automatic logic [W-1:0] window(input bit qq[$]);
    logic [W-1:0] w;
    w = '0;
    foreach (qq[i]) w = {w[W-2:0], qq[i]};
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_l.delete();
      mq_r.delete();
      p1 = '0; p2 = '0; p3 = '0;
      ew_l = '0; ew_r = '0;
      eu_l = 1'b0; eu_r = 1'b0;
    end else begin
      logic [4:0] cur;
      cur = {lat_r, lat_l, din_r, din_l, bclk};
      eu_l = 1'b0;
      eu_r = 1'b0;
      if (p2[0] && !p3[0]) begin
        mq_l.push_back(p2[1]);
        mq_r.push_back(p2[2]);
        if (mq_l.size() > W) void'(mq_l.pop_front());
        if (mq_r.size() > W) void'(mq_r.pop_front());
      end
      if (!p2[3] && p3[3]) begin
        ew_l = window(mq_l);
        eu_l = 1'b1;
      end
      if (!p2[4] && p3[4]) begin
        ew_r = window(mq_r);
        eu_r = 1'b1;
      end
      p3 = p2;
      p2 = p1;
      p1 = cur;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 word_l model", 32'(word_l_o), 32'(ew_l));
      chk("R3 word_r model", 32'(word_r_o), 32'(ew_r));
      chk("R8 obin_l model", 32'(obin_l_o), 32'(ew_l ^ SIGN));
      chk("R8 obin_r model", 32'(obin_r_o), 32'(ew_r ^ SIGN));
      chk("R7 upd_l model", 32'(upd_l_o), 32'(eu_l));
      chk("R7 upd_r model", 32'(upd_r_o), 32'(eu_r));
      if (upd_l_o) upd_l_seen++;
      if (upd_r_o) upd_r_seen++;
      if (in_tie && (upd_l_o != upd_r_o)) tie_mism++;
    end
  end

  task automatic send(input logic [31:0] wl, input logic [31:0] wr, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk);
      din_l = wl[i];
      din_r = wr[i];
      repeat (2) @(negedge clk);
      bclk = 1'b1;
      repeat (3) @(negedge clk);
      bclk = 1'b0;
    end
  endtask

  task automatic latch(input bit l, input bit r);
    @(negedge clk);
    if (l) lat_l = 1'b1;
    if (r) lat_r = 1'b1;
    repeat (3) @(negedge clk);
    lat_l = 1'b0;
    lat_r = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v_short, v_sim;
    repeat (5) @(negedge clk);
    // R1: values while reset is held
    chk("R1 word_l in reset", 32'(word_l_o), 32'h0);
    chk("R1 obin_r in reset", 32'(obin_r_o), 32'h20000);
    chk("R1 upd_l in reset", 32'(upd_l_o), 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 word_r after reset", 32'(word_r_o), 32'h0);
    chk("R1 obin_l after reset", 32'(obin_l_o), 32'h20000);

    // R2, R3, R8: one full word on each channel
    send(32'h2A5A3, 32'h15C3E, 18);
    latch(1'b1, 1'b1);
    chk("R2 R3 word_l", 32'(word_l_o), 32'h2A5A3);
    chk("R2 R3 word_r", 32'(word_r_o), 32'h15C3E);
    chk("R8 obin_l negative", 32'(obin_l_o), 32'h0A5A3);
    chk("R8 obin_r positive", 32'(obin_r_o), 32'h35C3E);

    // R4, R6: 22-bit word, only left latched
    send(32'h3ABCDE, 32'h000FF, 22);
    latch(1'b1, 1'b0);
    chk("R4 long word_l", 32'(word_l_o), 32'h2BCDE);
    chk("R6 word_r untouched", 32'(word_r_o), 32'h15C3E);

    // R4: short word keeps older bits above it
    send(32'h16, 32'h0, 5);
    latch(1'b1, 1'b0);
    v_short = W'(({14'h0, 18'h2BCDE} << 5) | 32'h16) & MASK;
    chk("R4 short word_l", 32'(word_l_o), 32'(v_short));

    // R5: rising latch edge captures nothing
    @(negedge clk);
    lat_l = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 word_l after latch rise", 32'(word_l_o), 32'(v_short));
    chk("R5 strobe count after rise", 32'(upd_l_seen), 32'd3);

    // R9: bit-clock rise and latch fall at the same edge
    v_sim = 18'h1F0F1;
    send(32'(v_sim >> 1), 32'h0, 17);
    @(negedge clk);
    din_l = v_sim[0];
    repeat (2) @(negedge clk);
    bclk  = 1'b1;
    lat_l = 1'b0;
    repeat (3) @(negedge clk);
    bclk = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 same-cycle shift then capture", 32'(word_l_o), 32'(v_sim));

    // R10: tied data and tied latch
    in_tie = 1'b1;
    send(32'h0ACE1, 32'h0ACE1, 18);
    latch(1'b1, 1'b1);
    in_tie = 1'b0;
    chk("R10 tied word_l", 32'(word_l_o), 32'h0ACE1);
    chk("R10 tied word_r", 32'(word_r_o), 32'h0ACE1);
    chk("R10 strobes aligned", 32'(tie_mism), 32'd0);
    chk("R8 obin_l tied", 32'(obin_l_o), 32'h2ACE1);

    // R7: one pulse per capture
    chk("R7 left strobe count", 32'(upd_l_seen), 32'd5);
    chk("R7 right strobe count", 32'(upd_r_seen), 32'd2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule